// File: doc/BRIEF.md
# Write Wrapper with Size-Switched Data Buffer

This block sits between a bus master core and the shared command/write-data bus. It carries one write burst at a time. The core hands over an address, a burst size code and a command identifier. The wrapper then puts a request on the bus that carries those fields together with a fixed master identifier and the write command code. The target answers with an acceptance or with a refusal that includes a back-off interval. After a refusal the wrapper drops the request for exactly that many cycles and then raises it again.

Each burst takes one of two data paths, chosen by comparing its byte count with a small local buffer. If the burst fits, the wrapper collects every beat from the core first and only then issues the request. Once the request is accepted, it streams the buffered beats on consecutive cycles without involving the core. If the burst is larger than the buffer, the request goes out at once and the core is held off until acceptance. The core's beats then pass straight through to the bus, one per cycle in which the core offers one.

Top module: `wbs_master_wrapper`

## Requirements
- R1: While reset is held and immediately after it, core_req_ready is 1 and core_wdata_ready, bus_req, bus_wvalid and bus_wlast are 0.
- R2: The 3-bit size code k selects a burst of 8<<k bytes for k from 0 to 4. Codes 5, 6 and 7 select 128 bytes. The burst carries bytes/(DATA_W/8) data beats on the bus, and bus_wlast marks the last of them.
- R3: A burst whose byte count is at most BUF_BYTES is buffered. core_wdata_ready is 1 from the cycle after the command is taken until all of its beats have been taken, and bus_req stays 0 until then.
- R4: On a buffered burst, bus_wvalid is 1 from the cycle after the accepting response for exactly the beat count of consecutive cycles. The beats appear in the order the core delivered them.
- R5: A burst larger than BUF_BYTES raises bus_req in the cycle after the command is taken and keeps core_wdata_ready at 0 until the cycle after acceptance. From then on, bus_wvalid equals core_wdata_valid and bus_wdata equals core_wdata in the same cycle, until the beat count has been transferred.
- R6: While bus_req is 1, bus_addr, bus_size and bus_cmd_id hold the values of the accepted command, bus_mid equals MASTER_ID and bus_cmd is the write code 2'b01.
- R7: A refusal (bus_nack=1, bus_ack=0 while bus_req=1) with interval N>0 makes bus_req 0 for exactly N cycles before it returns. With N=0 the request stays up in the next cycle.
- R8: When bus_ack and bus_nack are both 1 in a request cycle, the response counts as acceptance.
- R9: core_req_ready falls in the cycle after a command is taken and returns only in the cycle after the last data beat.
- R10: bus_ack and bus_nack have no effect while bus_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core offers a write command |
| core_req_ready | output | 1 | Wrapper can take a command |
| core_addr | input | ADDR_W | Burst start address |
| core_size | input | 3 | Burst size code |
| core_cmd_id | input | ID_W | Command identifier |
| core_wdata_valid | input | 1 | Core offers a data beat |
| core_wdata | input | DATA_W | Data beat from core |
| core_wdata_ready | output | 1 | Wrapper takes a data beat |
| bus_req | output | 1 | Request on the command bus |
| bus_cmd | output | 2 | Command code (write = 2'b01) |
| bus_addr | output | ADDR_W | Request address |
| bus_size | output | 3 | Request size code |
| bus_cmd_id | output | ID_W | Request command identifier |
| bus_mid | output | MID_W | Master identifier |
| bus_ack | input | 1 | Target accepts the request |
| bus_nack | input | 1 | Target refuses the request |
| bus_retry | input | RETRY_W | Back-off interval in cycles |
| bus_wvalid | output | 1 | Write beat on the bus |
| bus_wdata | output | DATA_W | Write beat data |
| bus_wlast | output | 1 | Final beat of the burst |

## Verification
Acceptance and refusal can arrive in the same request cycle. Acceptance must then win, on both data paths. The bench provokes this by scripting a combined response for one buffered burst and one pass-through burst. In the following cycle it checks that the request has dropped and that either streaming has begun or the core is being asked for data. The bench also drives combined responses into an idle wrapper and checks that nothing moves.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FILL = 3'd1,
        ST_REQ  = 3'd2,
        ST_WAIT = 3'd3,
        ST_BSTR = 3'd4,
        ST_PASS = 3'd5
    } wbs_state_e;

    localparam logic [1:0] CMD_WRITE = 2'b01;

    // size code to byte count; codes above 4 clamp to the largest burst
    function automatic logic [8:0] burst_bytes(input logic [2:0] code);
        logic [2:0] k;
        k = (code > 3'd4) ? 3'd4 : code;
        return 9'(9'd8 << k);
    endfunction

endpackage

// File: rtl/wbs_size_decode.sv
module wbs_size_decode #(
    parameter int DATA_W    = 32,
    parameter int BUF_BYTES = 16,
    parameter int BEAT_W    = 6
) (
    input  logic [2:0]        size_code,
    output logic [BEAT_W-1:0] beats,
    output logic              fits
);
    localparam int BPB = DATA_W / 8;

    logic [8:0] nbytes;

    always_comb begin
        nbytes = wbs_pkg::burst_bytes(size_code);
        beats  = BEAT_W'(nbytes / 9'(BPB));
        fits   = (32'(nbytes) <= 32'(BUF_BYTES));
    end

endmodule

// File: rtl/wbs_wbuf.sv
module wbs_wbuf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [LVL_W-1:0]             lvl;
    } buf_t;

    buf_t buf_d, buf_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (32'(p) == DEPTH - 1) ? '0 : PTR_W'(p + 1'b1);
    endfunction

    always_comb begin
        buf_d = buf_q;
        if (clr) begin
            buf_d.wp  = '0;
            buf_d.rp  = '0;
            buf_d.lvl = '0;
        end else begin
            if (wr_en) begin
                buf_d.mem[buf_q.wp] = wdata;
                buf_d.wp            = bump(buf_q.wp);
            end
            if (rd_en) begin
                buf_d.rp = bump(buf_q.rp);
            end
            buf_d.lvl = LVL_W'(buf_q.lvl + LVL_W'(wr_en) - LVL_W'(rd_en));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign rdata = buf_q.mem[buf_q.rp];

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |-> (32'(buf_q.lvl) < DEPTH));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !clr) |-> (buf_q.lvl != '0));

endmodule

// File: rtl/wbs_backoff.sv
module wbs_backoff #(
    parameter int RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [RETRY_W-1:0] load_val,
    output logic               expired
);
    typedef struct packed {
        logic [RETRY_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load)                 tmr_d.cnt = load_val;
        else if (tmr_q.cnt != '0) tmr_d.cnt = RETRY_W'(tmr_q.cnt - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = (tmr_q.cnt == '0);

endmodule

// File: rtl/wbs_master_wrapper.sv
module wbs_master_wrapper #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int BUF_BYTES = 16,
    parameter int ID_W      = 4,
    parameter int MID_W     = 3,
    parameter int MASTER_ID = 2,
    parameter int RETRY_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_req_valid,
    output logic               core_req_ready,
    input  logic [ADDR_W-1:0]  core_addr,
    input  logic [2:0]         core_size,
    input  logic [ID_W-1:0]    core_cmd_id,
    input  logic               core_wdata_valid,
    input  logic [DATA_W-1:0]  core_wdata,
    output logic               core_wdata_ready,
    output logic               bus_req,
    output logic [1:0]         bus_cmd,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [2:0]         bus_size,
    output logic [ID_W-1:0]    bus_cmd_id,
    output logic [MID_W-1:0]   bus_mid,
    input  logic               bus_ack,
    input  logic               bus_nack,
    input  logic [RETRY_W-1:0] bus_retry,
    output logic               bus_wvalid,
    output logic [DATA_W-1:0]  bus_wdata,
    output logic               bus_wlast
);
    import wbs_pkg::*;

    localparam int BPB       = DATA_W / 8;
    localparam int MAX_BEATS = 128 / BPB;
    localparam int BEAT_W    = $clog2(MAX_BEATS + 1);
    localparam int BUF_BEATS = BUF_BYTES / BPB;
    localparam int BUF_DEPTH = (BUF_BEATS < 1) ? 1 : BUF_BEATS;

    typedef struct packed {
        wbs_state_e        st;
        logic [BEAT_W-1:0] total;
        logic [BEAT_W-1:0] cnt;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        size;
        logic [ID_W-1:0]   cid;
        logic              buffered;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [BEAT_W-1:0]  dec_beats;
    logic               dec_fits;
    logic               buf_clr, buf_wr, buf_rd;
    logic [DATA_W-1:0]  buf_rdata;
    logic               tmr_load, tmr_expired;
    logic [RETRY_W-1:0] tmr_val;
    logic               last_beat;

    wbs_size_decode #(
        .DATA_W   (DATA_W),
        .BUF_BYTES(BUF_BYTES),
        .BEAT_W   (BEAT_W)
    ) size_dec_i (
        .size_code(core_size),
        .beats    (dec_beats),
        .fits     (dec_fits)
    );

    wbs_wbuf #(
        .DATA_W(DATA_W),
        .DEPTH (BUF_DEPTH)
    ) wbuf_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (buf_clr),
        .wr_en(buf_wr),
        .wdata(core_wdata),
        .rd_en(buf_rd),
        .rdata(buf_rdata)
    );

    wbs_backoff #(
        .RETRY_W(RETRY_W)
    ) backoff_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    assign last_beat = (ctl_q.cnt == BEAT_W'(ctl_q.total - 1'b1));

    always_comb begin
        ctl_d            = ctl_q;
        core_req_ready   = 1'b0;
        core_wdata_ready = 1'b0;
        bus_req          = 1'b0;
        bus_wvalid       = 1'b0;
        bus_wdata        = '0;
        bus_wlast        = 1'b0;
        buf_clr          = 1'b0;
        buf_wr           = 1'b0;
        buf_rd           = 1'b0;
        tmr_load         = 1'b0;
        tmr_val          = RETRY_W'(bus_retry - 1'b1);

        unique case (ctl_q.st)
            ST_IDLE: begin
                core_req_ready = 1'b1;
                if (core_req_valid) begin
                    ctl_d.addr     = core_addr;
                    ctl_d.size     = core_size;
                    ctl_d.cid      = core_cmd_id;
                    ctl_d.total    = dec_beats;
                    ctl_d.cnt      = '0;
                    ctl_d.buffered = dec_fits;
                    buf_clr        = 1'b1;
                    ctl_d.st       = dec_fits ? ST_FILL : ST_REQ;
                end
            end
            ST_FILL: begin
                core_wdata_ready = 1'b1;
                if (core_wdata_valid) begin
                    buf_wr    = 1'b1;
                    ctl_d.cnt = BEAT_W'(ctl_q.cnt + 1'b1);
                    if (last_beat) begin
                        ctl_d.cnt = '0;
                        ctl_d.st  = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                bus_req = 1'b1;
                if (bus_ack) begin
                    ctl_d.cnt = '0;
                    ctl_d.st  = ctl_q.buffered ? ST_BSTR : ST_PASS;
                end else if (bus_nack && (bus_retry != '0)) begin
                    tmr_load = 1'b1;
                    ctl_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (tmr_expired) ctl_d.st = ST_REQ;
            end
            ST_BSTR: begin
                bus_wvalid = 1'b1;
                bus_wdata  = buf_rdata;
                bus_wlast  = last_beat;
                buf_rd     = 1'b1;
                ctl_d.cnt  = BEAT_W'(ctl_q.cnt + 1'b1);
                if (last_beat) ctl_d.st = ST_IDLE;
            end
            ST_PASS: begin
                core_wdata_ready = 1'b1;
                bus_wvalid       = core_wdata_valid;
                bus_wdata        = core_wdata;
                bus_wlast        = core_wdata_valid && last_beat;
                if (core_wdata_valid) begin
                    ctl_d.cnt = BEAT_W'(ctl_q.cnt + 1'b1);
                    if (last_beat) ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign bus_cmd    = CMD_WRITE;
    assign bus_addr   = ctl_q.addr;
    assign bus_size   = ctl_q.size;
    assign bus_cmd_id = ctl_q.cid;
    assign bus_mid    = MID_W'(MASTER_ID);

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_req_valid && core_req_ready) |=> !core_req_ready);

    // R9
    release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wvalid && bus_wlast) |=> core_req_ready);

    // R7
    backoff_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_nack && !bus_ack && (bus_retry != '0)) |=> !bus_req);

    // R7
    zero_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_nack && !bus_ack && (bus_retry == '0)) |=> bus_req);

    // R8
    ack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (!bus_req && (bus_wvalid || core_wdata_ready)));

    // R6
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_size) && $stable(bus_cmd_id)));

    // R3
    no_data_during_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && core_wdata_ready));

    // R4
    stream_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_BSTR && !bus_wlast) |=> bus_wvalid);

endmodule

// File: tb/wbs_master_wrapper_tb_top.sv
module wbs_master_wrapper_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int BUF_BYTES  = 16;
    localparam int ID_W       = 4;
    localparam int MID_W      = 3;
    localparam int MASTER_ID  = 2;
    localparam int RETRY_W    = 8;
    localparam int WD_LIMIT   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_req_valid = 1'b0;
    logic core_req_ready;
    logic [ADDR_W-1:0] core_addr = '0;
    logic [2:0] core_size = '0;
    logic [ID_W-1:0] core_cmd_id = '0;
    logic core_wdata_valid = 1'b0;
    logic [DATA_W-1:0] core_wdata = '0;
    logic core_wdata_ready;
    logic bus_req;
    logic [1:0] bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [2:0] bus_size;
    logic [ID_W-1:0] bus_cmd_id;
    logic [MID_W-1:0] bus_mid;
    logic bus_ack = 1'b0;
    logic bus_nack = 1'b0;
    logic [RETRY_W-1:0] bus_retry = '0;
    logic bus_wvalid;
    logic [DATA_W-1:0] bus_wdata;
    logic bus_wlast;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbs_master_wrapper #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES), .ID_W(ID_W),
        .MID_W(MID_W), .MASTER_ID(MASTER_ID), .RETRY_W(RETRY_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
        .core_addr(core_addr), .core_size(core_size), .core_cmd_id(core_cmd_id),
        .core_wdata_valid(core_wdata_valid), .core_wdata(core_wdata),
        .core_wdata_ready(core_wdata_ready),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_cmd_id(bus_cmd_id), .bus_mid(bus_mid),
        .bus_ack(bus_ack), .bus_nack(bus_nack), .bus_retry(bus_retry),
        .bus_wvalid(bus_wvalid), .bus_wdata(bus_wdata), .bus_wlast(bus_wlast)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic int beats_of(input logic [2:0] code);
        int nb;
        nb = (code > 3'd4) ? 128 : (8 << code);
        return nb / (DATA_W / 8);
    endfunction

    function automatic int bytes_of(input logic [2:0] code);
        return (code > 3'd4) ? 128 : (8 << code);
    endfunction

    // ---------------- behavioural reference ----------------
    // phases: 0 idle, 1 collecting, 2 requesting, 3 backing off, 4 draining, 5 forwarding
    int m_ph = 0;
    int m_total = 0;
    int m_cnt = 0;
    int m_wait = 0;
    bit m_buffered = 0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic [2:0] m_size = '0;
    logic [ID_W-1:0] m_cid = '0;
    logic [DATA_W-1:0] m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0;
            m_q.delete();
        end else begin
            case (m_ph)
                0: if (core_req_valid) begin
                    m_addr = core_addr; m_size = core_size; m_cid = core_cmd_id;
                    m_total = beats_of(core_size);
                    m_buffered = (bytes_of(core_size) <= BUF_BYTES);
                    m_q.delete();
                    m_cnt = 0;
                    m_ph = m_buffered ? 1 : 2;
                end
                1: if (core_wdata_valid) begin
                    m_q.push_back(core_wdata);
                    if (m_q.size() == m_total) m_ph = 2;
                end
                2: if (bus_ack) begin
                    m_cnt = 0;
                    m_ph = m_buffered ? 4 : 5;
                end else if (bus_nack && bus_retry != 0) begin
                    m_wait = int'(bus_retry);
                    m_ph = 3;
                end
                3: begin
                    m_wait--;
                    if (m_wait == 0) m_ph = 2;
                end
                4: begin
                    if (m_q.size() > 0) void'(m_q.pop_front());
                    m_cnt++;
                    if (m_cnt == m_total) m_ph = 0;
                end
                5: if (core_wdata_valid) begin
                    m_cnt++;
                    if (m_cnt == m_total) m_ph = 0;
                end
                default: m_ph = 0;
            endcase
        end
    end

    // ---------------- stimulus agents and per-cycle comparison ----------------
    int dseq = 1;
    bit acc_pend = 0;
    bit s_skip = 1;
    bit spur = 0;
    bit prev_both = 0;
    int s_resp[$];
    int exp_beats[$];
    int mon_beats = 0;

    task automatic compare_cycle();
        string tag;
        bit e_rr, e_wr, e_req, e_wv, e_wl;
        logic [DATA_W-1:0] e_wd;
        tag = (m_ph == 1) ? "R3" : (m_ph == 4) ? "R4" : (m_ph == 5) ? "R5" :
              (m_ph == 3) ? "R7" : "R9";
        e_rr  = (m_ph == 0);
        e_wr  = (m_ph == 1) || (m_ph == 5);
        e_req = (m_ph == 2);
        e_wv  = (m_ph == 4) || (m_ph == 5 && core_wdata_valid);
        e_wd  = (m_ph == 4) ? ((m_q.size() > 0) ? m_q[0] : '0) : core_wdata;
        e_wl  = e_wv && (m_cnt == m_total - 1);
        chk(core_req_ready == e_rr, "R9", "core_req_ready", 64'(core_req_ready), 64'(e_rr));
        chk(core_wdata_ready == e_wr, tag, "core_wdata_ready", 64'(core_wdata_ready), 64'(e_wr));
        chk(bus_req == e_req, (m_ph == 3 || m_ph == 2) ? "R7" : tag, "bus_req", 64'(bus_req), 64'(e_req));
        chk(bus_wvalid == e_wv, tag, "bus_wvalid", 64'(bus_wvalid), 64'(e_wv));
        if (e_wv) begin
            chk(bus_wdata == e_wd, tag, "bus_wdata", 64'(bus_wdata), 64'(e_wd));
            chk(bus_wlast == e_wl, "R2", "bus_wlast", 64'(bus_wlast), 64'(e_wl));
        end
        if (e_req) begin
            chk(bus_addr == m_addr, "R6", "bus_addr", 64'(bus_addr), 64'(m_addr));
            chk(bus_size == m_size, "R6", "bus_size", 64'(bus_size), 64'(m_size));
            chk(bus_cmd_id == m_cid, "R6", "bus_cmd_id", 64'(bus_cmd_id), 64'(m_cid));
            chk(bus_mid == MID_W'(MASTER_ID), "R6", "bus_mid", 64'(bus_mid), 64'(MASTER_ID));
            chk(bus_cmd == 2'b01, "R6", "bus_cmd", 64'(bus_cmd), 64'(2'b01));
        end
        // R8: previous request cycle carried ack and nack together
        if (prev_both)
            chk(!bus_req && (bus_wvalid || core_wdata_ready), "R8", "accept after ack+nack",
                64'({bus_req, bus_wvalid, core_wdata_ready}), 64'(3'b010));
        // R2: beat count per burst
        if (bus_wvalid) begin
            mon_beats++;
            if (bus_wlast) begin
                int eb;
                eb = (exp_beats.size() > 0) ? exp_beats.pop_front() : -1;
                chk(mon_beats == eb, "R2", "beats per burst", 64'(mon_beats), 64'(eb));
                mon_beats = 0;
            end
        end
    endtask

    always @(negedge clk) begin
        int r;
        if (acc_pend) dseq++;
        core_wdata_valid = ($urandom_range(3) != 0);
        core_wdata = DATA_W'(dseq) * DATA_W'(32'h00010003) + DATA_W'(5);
        bus_ack = 1'b0; bus_nack = 1'b0; bus_retry = RETRY_W'(9);
        if (rst_n && bus_req) begin
            if (s_skip) s_skip = 0;
            else begin
                s_skip = 1;
                r = (s_resp.size() > 0) ? s_resp.pop_front() : -1;
                if (r == -1) bus_ack = 1'b1;
                else if (r == -2) begin bus_ack = 1'b1; bus_nack = 1'b1; bus_retry = RETRY_W'(4); end
                else begin bus_nack = 1'b1; bus_retry = RETRY_W'(r); end
            end
        end else begin
            s_skip = 1;
            if (spur) begin bus_ack = 1'b1; bus_nack = 1'b1; bus_retry = RETRY_W'(2); end
        end
        #1;
        if (rst_n) compare_cycle();
        prev_both = rst_n && bus_req && bus_ack && bus_nack;
        acc_pend = core_wdata_valid && core_wdata_ready;
    end

    // watchdog
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles >= WD_LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=%0d expected<%0d cycles", cycles, WD_LIMIT);
            finish_run();
        end
    end

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [2:0] code,
                            input logic [ID_W-1:0] id);
        @(negedge clk);
        core_req_valid = 1'b1;
        core_addr = a; core_size = code; core_cmd_id = id;
        forever begin
            #2;
            if (core_req_ready) break;
            @(negedge clk);
        end
        exp_beats.push_back(beats_of(code));
        @(negedge clk);
        core_req_valid = 1'b0;
        core_addr = ~a;
        core_cmd_id = ~id;
        do begin
            @(negedge clk);
            #2;
        end while (!core_req_ready);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2;
        // R1 reset state while reset held
        chk(core_req_ready == 1'b1 && core_wdata_ready == 1'b0 && bus_req == 1'b0 &&
            bus_wvalid == 1'b0 && bus_wlast == 1'b0, "R1", "outputs in reset",
            64'({core_req_ready, core_wdata_ready, bus_req, bus_wvalid, bus_wlast}), 64'(5'b10000));
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(core_req_ready == 1'b1 && bus_req == 1'b0 && bus_wvalid == 1'b0, "R1",
            "outputs after reset", 64'({core_req_ready, bus_req, bus_wvalid}), 64'(3'b100));

        // R3 R4: 8-byte buffered, accepted
        do_write(32'h0000_1000, 3'd0, 4'h1);
        // R3 R7: 16-byte buffered, refused with interval 3
        s_resp.push_back(3);
        do_write(32'h0000_2000, 3'd1, 4'h2);
        // R5 R7: 32-byte pass-through, refusals with 0 and 1
        s_resp.push_back(0); s_resp.push_back(1);
        do_write(32'h0000_3000, 3'd2, 4'h3);
        // R5 R8: 128-byte pass-through, combined response
        s_resp.push_back(-2);
        do_write(32'h0000_4000, 3'd4, 4'h4);
        // R4 R8: buffered with combined response
        s_resp.push_back(-2);
        do_write(32'h0000_5000, 3'd1, 4'h5);
        // R2: clamped size code
        do_write(32'h0000_6000, 3'd7, 4'h6);
        // R5 R7: 64-byte pass-through, interval 2
        s_resp.push_back(2);
        do_write(32'h0000_7000, 3'd3, 4'h7);

        // R10: responses while idle change nothing
        spur = 1;
        repeat (3) @(negedge clk);
        #2;
        chk(core_req_ready == 1'b1 && bus_req == 1'b0 && bus_wvalid == 1'b0, "R10",
            "idle after stray responses", 64'({core_req_ready, bus_req, bus_wvalid}), 64'(3'b100));
        spur = 0;
        // R9 still accepts next command normally
        do_write(32'h0000_8000, 3'd0, 4'h8);
        chk(exp_beats.size() == 0, "R2", "all bursts ended with last", 64'(exp_beats.size()), 64'(0));
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule